// File: doc/BRIEF.md
# Seven-Slot Serial Display Link Deserializer

This block sits behind the differential line receivers of a flat-panel video link. It takes three serial data lanes and one forwarded clock lane. All four lanes are sampled once per cycle of a bit-rate clock, and each pixel period spans seven consecutive samples (slots). The block finds the seven-slot frame boundary from the waveform on the clock lane. It then gathers the seven bits of every data lane into one 21-bit pixel word: 18 colour bits plus horizontal sync, vertical sync and data enable.

The word is presented together with a rebuilt pixel clock. That clock is high for four slots and low for three, and the consumer latches the data on its falling edge. A lock flag reports that the clock lane has kept its expected shape for several frames in a row. An active-low power-down input forces every output low and drops alignment and lock. The analog front end, any PLL and any skew calibration sit outside this block.

Top module: `lvds_display_deser`

## Requirements
- R1: For each frame, the slot-n sample of data lane k becomes bit 7k+n of the 21-bit pixel word, so a word serialised with that mapping comes back unchanged.
- R2: Pixel word fields: bits 5:0 red, 11:6 green, 17:12 blue, bit 18 horizontal sync, bit 19 vertical sync, bit 20 data enable.
- R3: A frame begins at the sample where the clock lane reads 1 after reading 0 on the previous sample. Until the first such sample, the word outputs, the pixel clock and the lock flag stay 0.
- R4: The word outputs take a new frame's value in the cycle after that frame's slot-6 sample and hold it until the next frame's slot-6 sample.
- R5: The pixel clock reads 1 for slots 0 to 3 and 0 for slots 4 to 6 (registered one cycle after each sample), so its falling edge lies in a span where the word is stable. It is also 0 for any sample that breaks the clock-lane shape.
- R6: The expected clock-lane shape is 1 in slots 0 to 3 and 0 in slots 4 to 6. The lock flag rises at the end of the third consecutive frame with that shape. Any deviation, whether a wrong level or a low-to-high step outside slot 0, clears the lock flag and restarts the count.
- R7: A low-to-high step on the clock lane at an unexpected slot realigns the slot count to it, and the frame starting there is decoded correctly.
- R8: While the power-down input is 0, all outputs (word fields, pixel clock, lock flag) are 0. Alignment and lock are dropped, and after release three good frames are again needed for lock.
- R9: Synchronous active-high reset clears the word, the pixel clock, the alignment and the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| ser_lane | input | 3 | Serial data lanes, one sample per slot |
| ser_clk_lane | input | 1 | Sampled forwarded clock lane |
| pix_clk | output | 1 | Rebuilt pixel clock, falling edge is the data strobe |
| pix_red | output | 6 | Red field of the pixel word |
| pix_grn | output | 6 | Green field of the pixel word |
| pix_blu | output | 6 | Blue field of the pixel word |
| pix_hsync | output | 1 | Horizontal sync bit |
| pix_vsync | output | 1 | Vertical sync bit |
| pix_de | output | 1 | Data enable bit |
| link_locked | output | 1 | Clock-lane shape held for the required number of frames |

## Verification
The bench builds the block with its default values: three lanes, seven slots, four high slots and a lock depth of three frames. With a lock depth of three, the exact frame at which lock rises is reached within a handful of frames, and it can be hit again after a broken clock-lane shape, after a phase slip and after power-down. The seven-slot frame lets every slot's contribution to the pixel clock be compared against the four-high, three-low shape in each frame.

// File: rtl/lvds_rx_pkg.sv
package lvds_rx_pkg;

    parameter int unsigned LANES      = 3;
    parameter int unsigned SLOTS      = 7;
    parameter int unsigned HIGH_SLOTS = 4;
    parameter int unsigned COLOR_W    = 6;

    localparam int unsigned WORD_W = LANES * SLOTS;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;

    // Pixel word, MSB first: enable, vsync, hsync, blue, green, red.
    typedef struct packed {
        logic               de;
        logic               vsync;
        logic               hsync;
        logic [COLOR_W-1:0] blu;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] red;
    } pix_word_t;

    // Expected clock-lane level for a slot.
    function automatic logic clk_level(input slot_t s);
        return (32'(s) < HIGH_SLOTS);
    endfunction

endpackage

// File: rtl/lvds_rx_framer.sv
module lvds_rx_framer
    import lvds_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_dn_n,
    input  logic  ser_clk_lane,
    output slot_t cur_slot,
    output logic  slot_valid,
    output logic  shape_err,
    output logic  frame_end
);

    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

    logic  prev_q;
    logic  aligned_q;
    slot_t slot_q;
    logic  rise;

    assign rise       = !prev_q && ser_clk_lane;
    assign cur_slot   = rise ? '0 : slot_q;
    assign slot_valid = (aligned_q || rise) && pwr_dn_n;
    assign shape_err  = aligned_q && pwr_dn_n &&
                        ((rise && (slot_q != '0)) ||
                         (ser_clk_lane != clk_level(cur_slot)));
    assign frame_end  = slot_valid && (cur_slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b1;
            aligned_q <= 1'b0;
            slot_q    <= '0;
        end else begin
            prev_q <= ser_clk_lane;
            if (!pwr_dn_n) begin
                aligned_q <= 1'b0;
                slot_q    <= '0;
            end else begin
                aligned_q <= slot_valid;
                slot_q    <= (cur_slot == LAST_SLOT) ? '0 : slot_t'(cur_slot + 1'b1);
            end
        end
    end

endmodule

// File: rtl/lvds_rx_lane.sv
module lvds_rx_lane
    import lvds_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    input  logic             slot_valid,
    input  slot_t            cur_slot,
    output logic [SLOTS-1:0] frame_bits
);

    logic [SLOTS-1:0] bits_q;

    always_comb begin
        frame_bits           = bits_q;
        frame_bits[cur_slot] = ser_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (slot_valid) begin
            bits_q[cur_slot] <= ser_bit;
        end
    end

endmodule

// File: rtl/lvds_rx_lock.sv
module lvds_rx_lock #(
    parameter int unsigned LOCK_FRAMES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_dn_n,
    input  logic shape_err,
    input  logic frame_end,
    output logic locked
);

    localparam int unsigned CNT_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_FRAMES);

    logic [CNT_W-1:0] good_q;
    logic             bad_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n) begin
            good_q <= '0;
            bad_q  <= 1'b0;
        end else if (frame_end) begin
            bad_q <= 1'b0;
            if (bad_q || shape_err) begin
                good_q <= '0;
            end else if (good_q != CNT_MAX) begin
                good_q <= good_q + 1'b1;
            end
        end else if (shape_err) begin
            good_q <= '0;
            bad_q  <= 1'b1;
        end
    end

    assign locked = (good_q == CNT_MAX);

endmodule

// File: rtl/lvds_display_deser.sv
module lvds_display_deser
    import lvds_rx_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_dn_n,
    input  logic [LANES-1:0]   ser_lane,
    input  logic               ser_clk_lane,
    output logic               pix_clk,
    output logic [COLOR_W-1:0] pix_red,
    output logic [COLOR_W-1:0] pix_grn,
    output logic [COLOR_W-1:0] pix_blu,
    output logic               pix_hsync,
    output logic               pix_vsync,
    output logic               pix_de,
    output logic               link_locked
);

    slot_t            cur_slot;
    logic             slot_valid;
    logic             shape_err;
    logic             frame_end;
    logic             locked;
    logic [SLOTS-1:0] lane_bits [LANES];
    logic [WORD_W-1:0] word_next;
    pix_word_t        word_q;
    logic             pix_clk_q;

    lvds_rx_framer u_framer (
        .clk          (clk),
        .rst          (rst),
        .pwr_dn_n     (pwr_dn_n),
        .ser_clk_lane (ser_clk_lane),
        .cur_slot     (cur_slot),
        .slot_valid   (slot_valid),
        .shape_err    (shape_err),
        .frame_end    (frame_end)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lvds_rx_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .ser_bit    (ser_lane[k]),
            .slot_valid (slot_valid),
            .cur_slot   (cur_slot),
            .frame_bits (lane_bits[k])
        );
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            word_next[k*SLOTS +: SLOTS] = lane_bits[k];
        end
    end

    lvds_rx_lock #(
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_lock (
        .clk       (clk),
        .rst       (rst),
        .pwr_dn_n  (pwr_dn_n),
        .shape_err (shape_err),
        .frame_end (frame_end),
        .locked    (locked)
    );

    always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n) begin
            word_q    <= '0;
            pix_clk_q <= 1'b0;
        end else begin
            if (frame_end) begin
                word_q <= pix_word_t'(word_next);
            end
            pix_clk_q <= slot_valid && !shape_err && clk_level(cur_slot);
        end
    end

    assign pix_clk     = pwr_dn_n && pix_clk_q;
    assign pix_red     = pwr_dn_n ? word_q.red : '0;
    assign pix_grn     = pwr_dn_n ? word_q.grn : '0;
    assign pix_blu     = pwr_dn_n ? word_q.blu : '0;
    assign pix_hsync   = pwr_dn_n && word_q.hsync;
    assign pix_vsync   = pwr_dn_n && word_q.vsync;
    assign pix_de      = pwr_dn_n && word_q.de;
    assign link_locked = pwr_dn_n && locked;

endmodule

// File: rtl/lvds_display_deser_chk.sv
module lvds_display_deser_chk
    import lvds_rx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pwr_dn_n,
    input logic               pix_clk,
    input logic [COLOR_W-1:0] pix_red,
    input logic [COLOR_W-1:0] pix_grn,
    input logic [COLOR_W-1:0] pix_blu,
    input logic               pix_hsync,
    input logic               pix_vsync,
    input logic               pix_de,
    input logic               link_locked
);

    logic [WORD_W-1:0] w_cat;
    logic [3:0]        hi_run;

    assign w_cat = {pix_de, pix_vsync, pix_hsync, pix_blu, pix_grn, pix_red};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (!pix_clk) begin
            hi_run <= '0;
        end else if (hi_run != 4'hF) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R8: power-down holds every output low
    a_r8_pd_all_low: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |-> (w_cat == '0 && !pix_clk && !link_locked));

    // R5: falling strobe edge never coincides with a word change
    a_r5_strobe_stable: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn_n && $past(pwr_dn_n) && $fell(pix_clk)) |-> $stable(w_cat));

    // R4: the word changes only while the pixel clock is low
    a_r4_update_while_low: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn_n && $past(pwr_dn_n) && !$stable(w_cat)) |-> !pix_clk);

    // R6: lock rises only at a frame end, where the pixel clock is low
    a_r6_lock_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(link_locked) |-> (!pix_clk && pwr_dn_n));

    // R5: high phase never exceeds the high slot count
    a_r5_high_run: assert property (@(posedge clk) disable iff (rst)
        32'(hi_run) <= HIGH_SLOTS);

endmodule

bind lvds_display_deser lvds_display_deser_chk u_chk (.*);

// File: tb/tb_lvds_display_deser.sv
module tb_lvds_display_deser;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] GOOD_PAT = 7'b0001111;

    typedef struct packed {
        logic [20:0] w;
        logic        lk;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{21'h155555, 1'b0},
        '{21'h0AAAAA, 1'b0},
        '{21'h1FFFFF, 1'b1},
        '{21'h000000, 1'b1},
        '{21'h012345, 1'b1},
        '{21'h1C0E07, 1'b1},
        '{21'h03F03F, 1'b1},
        '{21'h100001, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic [2:0]  ser_lane = '0;
    logic        ser_clk_lane = 1'b0;
    logic        pix_clk;
    logic [5:0]  pix_red, pix_grn, pix_blu;
    logic        pix_hsync, pix_vsync, pix_de;
    logic        link_locked;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [6:0]  pc_cap;
    logic [20:0] mid_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvds_display_deser dut (
        .clk          (clk),
        .rst          (rst),
        .pwr_dn_n     (pwr_dn_n),
        .ser_lane     (ser_lane),
        .ser_clk_lane (ser_clk_lane),
        .pix_clk      (pix_clk),
        .pix_red      (pix_red),
        .pix_grn      (pix_grn),
        .pix_blu      (pix_blu),
        .pix_hsync    (pix_hsync),
        .pix_vsync    (pix_vsync),
        .pix_de       (pix_de),
        .link_locked  (link_locked)
    );

    function automatic logic [20:0] out_word();
        return {pix_de, pix_vsync, pix_hsync, pix_blu, pix_grn, pix_red};
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives one frame, ends at the falling edge
    // after the slot-6 sample has been taken.
    task automatic send_frame(input logic [20:0] w, input logic [6:0] pat);
        for (int s = 0; s < 7; s++) begin
            ser_clk_lane = pat[s];
            for (int k = 0; k < 3; k++) ser_lane[k] = w[7*k + s];
            @(negedge clk);
            pc_cap[s] = pix_clk;
            if (s == 3) mid_word = out_word();
        end
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) begin
            ser_clk_lane = 1'b0;
            ser_lane     = 3'b111;
            @(negedge clk);
        end
    endtask

    task automatic check_word(input string tag, input logic [20:0] w);
        check_val({tag, " word"}, 32'(out_word()), 32'(w));
        check_val({tag, " R2 red"},  32'(pix_red), 32'(w[5:0]));
        check_val({tag, " R2 green"}, 32'(pix_grn), 32'(w[11:6]));
        check_val({tag, " R2 blue"}, 32'(pix_blu), 32'(w[17:12]));
        check_val({tag, " R2 hs/vs/de"}, 32'({pix_de, pix_vsync, pix_hsync}), 32'(w[20:18]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (4) @(negedge clk);
        check_val("R9 reset word", 32'(out_word()), 32'h0);
        check_val("R9 reset pix_clk", 32'(pix_clk), 32'h0);
        check_val("R9 reset lock", 32'(link_locked), 32'h0);
        rst = 1'b0;

        // R3: data before any boundary is ignored
        idle_slots(6);
        check_val("R3 pre-align word", 32'(out_word()), 32'h0);
        check_val("R3 pre-align pix_clk", 32'(pix_clk), 32'h0);
        check_val("R3 pre-align lock", 32'(link_locked), 32'h0);

        // R1/R2/R4/R5/R6: table of frames
        for (int i = 0; i < 8; i++) begin
            send_frame(VEC[i].w, GOOD_PAT);
            check_word($sformatf("R1 vec%0d", i), VEC[i].w);
            check_val($sformatf("R6 lock vec%0d", i), 32'(link_locked), 32'(VEC[i].lk));
            check_val($sformatf("R5 pix_clk shape vec%0d", i), 32'(pc_cap), 32'(GOOD_PAT));
            if (i > 0)
                check_val($sformatf("R4 hold vec%0d", i), 32'(mid_word), 32'(VEC[i-1].w));
        end

        // R6: wrong level in slot 3 clears lock
        send_frame(21'h0F0F0F, 7'b0000111);
        check_val("R6 lock after bad shape", 32'(link_locked), 32'h0);
        send_frame(21'h111111, GOOD_PAT);
        send_frame(21'h022222, GOOD_PAT);
        check_val("R6 lock after two good", 32'(link_locked), 32'h0);
        send_frame(21'h133333, GOOD_PAT);
        check_val("R6 lock after three good", 32'(link_locked), 32'h1);

        // R7: phase slip by two slots, then realign
        idle_slots(2);
        send_frame(21'h0ABCDE, GOOD_PAT);
        check_word("R7 realigned", 21'h0ABCDE);
        check_val("R7 lock after slip", 32'(link_locked), 32'h0);

        // R8: power-down
        pwr_dn_n = 1'b0;
        send_frame(21'h1FFFFF, GOOD_PAT);
        check_val("R8 pd word", 32'(out_word()), 32'h0);
        check_val("R8 pd pix_clk seen", 32'(pc_cap), 32'h0);
        check_val("R8 pd lock", 32'(link_locked), 32'h0);
        pwr_dn_n = 1'b1;
        send_frame(21'h054321, GOOD_PAT);
        check_word("R8 after release", 21'h054321);
        send_frame(21'h065432, GOOD_PAT);
        check_val("R8 lock two after release", 32'(link_locked), 32'h0);
        send_frame(21'h076543, GOOD_PAT);
        check_val("R8 lock three after release", 32'(link_locked), 32'h1);
        check_word("R8 third frame", 21'h076543);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule